// File: doc/BRIEF.md
# Host Port DMA Byte Unpacker

This block carries 24-bit words from a DSP core out to an external DMA controller over an 8-bit parallel host port. The core writes a word into a one-word holding register. It is told that the register is free by an empty flag and, when enabled, by an interrupt request. Whenever the three-byte receive register is free, the held word moves into it on its own. The holding register then reports empty again, so the core can keep a second word waiting behind the one being read.

For each word, an internal byte-address counter is loaded from a two-bit width mode. The counter picks which byte the DMA controller reads. Byte address 5 selects the high byte, 6 the middle byte and 7 the low byte. The controller reads each byte with a request/acknowledge handshake. The acknowledge input is asynchronous and is synchronised inside the block. Each falling acknowledge steps the counter. Reading byte 7 frees the receive register, and if a second word is waiting it is loaded at once.

Top module: `hpd_unpacker`

## Requirements
- R1: After reset, tx_empty is 1, dma_req is 0, host_oe is 0, tx_overrun is 0 and tx_irq is 0 while the interrupt enable is 0.
- R2: A write strobe while tx_empty is 1 captures dsp_wdata and clears tx_empty from the next cycle. tx_irq equals tx_empty AND tx_irq_en.
- R3: When the receive register is free and the holding register is full, the word moves into the receive register on the next clock edge. This sets tx_empty again, which raises a second interrupt at once.
- R4: Each move loads the byte counter from the width mode sampled at that edge. Mode 0 loads 5, mode 1 loads 6, and mode 2 or 3 loads 7. Address 5 selects bits 23:16, address 6 selects bits 15:8 and address 7 selects bits 7:0. As a result, mode 0 sends 3 bytes, mode 1 sends 2 and mode 2 or 3 sends 1.
- R5: dma_req is 1 while a word is held in the receive register and the synchronised acknowledge is low. It falls within two clock edges after dma_ack rises.
- R6: While dma_ack is high, host_oe is 1 and host_data carries the byte chosen by the counter. While dma_ack is low, host_oe is 0.
- R7: Each falling edge of the synchronised acknowledge advances the counter exactly once unless the counter is 7. dma_req then returns for the next byte.
- R8: Reading byte 7 frees the receive register, and dma_req stays low if no word is waiting. If a word is waiting, it moves in on the same edge and its byte sequence starts.
- R9: A write strobe while tx_empty is 0 is ignored and the held word is unchanged. It sets tx_overrun, which stays 1 until reset.
- R10: Two words in flight leave the block in the order they were written. The second word's width comes from the mode value at the time it moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dsp_wr | input | 1 | DSP write strobe for the holding register |
| dsp_wdata | input | 24 | Word written by the DSP |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| width_mode | input | 2 | Bytes-per-word selection, sampled on each move |
| tx_empty | output | 1 | Holding register free |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_overrun | output | 1 | Sticky flag for a write that was dropped |
| dma_req | output | 1 | Byte request to the DMA controller |
| dma_ack | input | 1 | Byte acknowledge from the DMA controller, asynchronous |
| host_data | output | 8 | Byte driven toward the host bus |
| host_oe | output | 1 | Output enable for host_data |

## Verification
The assertions assume that dma_ack rises only while dma_req is high. They also assume that every acknowledge pulse lasts long enough to pass through the two-flop synchroniser, and that the low phase between pulses is equally long. The bench keeps within this rule. It raises acknowledge only after seeing a request, holds it for three clocks and keeps it low for four, and changes the width mode only while no move can take place.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int HPD_BYTE_W      = 8;
  localparam int HPD_NUM_BYTES   = 3;
  localparam int HPD_ADDR_W      = 3;
  localparam int HPD_LOW_ADDR    = 7;
  localparam int HPD_MODE_W      = 2;
  localparam int HPD_SYNC_STAGES = 2;
endpackage

// File: rtl/hpd_rst_sync.sv
module hpd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rst_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end

  assign rst_sync_n = rst_sh_q[1];
endmodule

// File: rtl/hpd_ack_sync.sv
module hpd_ack_sync #(
  parameter int STAGES = hpd_pkg::HPD_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_async_i,
  output logic ack_fall_o,
  output logic ack_busy_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;
  logic              prev_q;
  logic              ack_lvl;

  assign ack_lvl = sync_q[STAGES-1];

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], ack_async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= ack_lvl;
    end
  end

  // Single-cycle pulse on the synchronised falling edge
  assign ack_fall_o = prev_q & ~ack_lvl;
  // Covers the whole acknowledge window including the falling-edge cycle
  assign ack_busy_o = prev_q | ack_lvl;

  // R7
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall_o |=> !ack_fall_o);
endmodule

// File: rtl/hpd_tx_hold.sv
module hpd_tx_hold #(
  parameter int WORD_W = hpd_pkg::HPD_BYTE_W * hpd_pkg::HPD_NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              irq_en_i,
  input  logic              move_i,
  output logic              empty_o,
  output logic [WORD_W-1:0] word_o,
  output logic              irq_o,
  output logic              overrun_o
);
  logic              empty_q, empty_n;
  logic              ovr_q, ovr_n;
  logic [WORD_W-1:0] word_q;
  logic              word_en;

  always_comb begin
    empty_n = empty_q;
    ovr_n   = ovr_q;
    word_en = 1'b0;
    if (move_i) empty_n = 1'b1;
    if (wr_i) begin
      if (empty_q) begin
        empty_n = 1'b0;
        word_en = 1'b1;
      end else begin
        ovr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      empty_q <= empty_n;
      ovr_q   <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= wdata_i;
  end

  assign empty_o   = empty_q;
  assign word_o    = word_q;
  assign irq_o     = empty_q & irq_en_i;
  assign overrun_o = ovr_q;

  // R2
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && empty_q) |=> !empty_q);
  // R3
  move_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_i |-> !empty_q);
  // R9
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !empty_q) |=> ($stable(word_q) && ovr_q));
endmodule

// File: rtl/hpd_rx_unpack.sv
module hpd_rx_unpack #(
  parameter int BYTE_W    = hpd_pkg::HPD_BYTE_W,
  parameter int NUM_BYTES = hpd_pkg::HPD_NUM_BYTES,
  parameter int ADDR_W    = hpd_pkg::HPD_ADDR_W,
  parameter int LOW_ADDR  = hpd_pkg::HPD_LOW_ADDR,
  parameter int MODE_W    = hpd_pkg::HPD_MODE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_empty_i,
  input  logic [BYTE_W*NUM_BYTES-1:0] hold_word_i,
  input  logic [MODE_W-1:0]           mode_i,
  input  logic                        ack_raw_i,
  input  logic                        ack_fall_i,
  input  logic                        ack_busy_i,
  output logic                        move_o,
  output logic                        req_o,
  output logic [BYTE_W-1:0]           bus_data_o,
  output logic                        bus_oe_o
);
  localparam int WORD_W = BYTE_W * NUM_BYTES;
  localparam logic [ADDR_W-1:0] LOW_A = ADDR_W'(LOW_ADDR);
  localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(LOW_ADDR - NUM_BYTES + 1);

  logic [NUM_BYTES-1:0][BYTE_W-1:0] rx_q;
  logic                             full_q, full_n;
  logic [ADDR_W-1:0]                cnt_q, cnt_n;
  logic [ADDR_W-1:0]                load_addr;
  logic                             last_rd, step;
  logic [BYTE_W-1:0]                sel_byte;

  // Width mode to starting byte address, clamped at the low byte
  always_comb begin
    if (int'(mode_i) >= NUM_BYTES - 1) load_addr = LOW_A;
    else                                load_addr = HI_A + ADDR_W'(mode_i);
  end

  assign last_rd = ack_fall_i & full_q & (cnt_q == LOW_A);
  assign step    = ack_fall_i & full_q & (cnt_q != LOW_A);
  assign move_o  = ~tx_empty_i & (~full_q | last_rd);

  always_comb begin
    full_n = full_q;
    cnt_n  = cnt_q;
    if (move_o) begin
      full_n = 1'b1;
      cnt_n  = load_addr;
    end else if (last_rd) begin
      full_n = 1'b0;
    end else if (step) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= HI_A;
    end else begin
      full_q <= full_n;
      cnt_q  <= cnt_n;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BYTES; gi++) begin : g_rx_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rx_q[gi] <= '0;
        else if (move_o) rx_q[gi] <= hold_word_i[gi*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  // Address HI_A+i selects byte NUM_BYTES-1-i (high byte first)
  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (cnt_q == HI_A + ADDR_W'(i)) sel_byte = rx_q[NUM_BYTES-1-i];
    end
  end

  assign req_o      = full_q & ~ack_busy_i;
  assign bus_oe_o   = ack_raw_i;
  assign bus_data_o = ack_raw_i ? sel_byte : '0;

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= HI_A) && (cnt_q <= LOW_A));
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall_i && full_q && cnt_q != LOW_A) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8
  low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall_i && full_q && cnt_q == LOW_A && tx_empty_i) |=> !full_q);
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_busy_i) |-> !req_o);
  // R3
  move_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_o |=> (full_q && cnt_q == $past(load_addr)));

  logic unused_w;
  assign unused_w = ^WORD_W;
endmodule

// File: rtl/hpd_unpacker.sv
module hpd_unpacker #(
  parameter int BYTE_W      = hpd_pkg::HPD_BYTE_W,
  parameter int NUM_BYTES   = hpd_pkg::HPD_NUM_BYTES,
  parameter int ADDR_W      = hpd_pkg::HPD_ADDR_W,
  parameter int LOW_ADDR    = hpd_pkg::HPD_LOW_ADDR,
  parameter int MODE_W      = hpd_pkg::HPD_MODE_W,
  parameter int SYNC_STAGES = hpd_pkg::HPD_SYNC_STAGES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dsp_wr,
  input  logic [BYTE_W*NUM_BYTES-1:0] dsp_wdata,
  input  logic                        tx_irq_en,
  input  logic [MODE_W-1:0]           width_mode,
  output logic                        tx_empty,
  output logic                        tx_irq,
  output logic                        tx_overrun,
  output logic                        dma_req,
  input  logic                        dma_ack,
  output logic [BYTE_W-1:0]           host_data,
  output logic                        host_oe
);
  localparam int WORD_W = BYTE_W * NUM_BYTES;

  logic              rst_i_n;
  logic              move;
  logic              ack_fall, ack_busy;
  logic [WORD_W-1:0] hold_word;

  hpd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  hpd_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ack_async_i (dma_ack),
    .ack_fall_o  (ack_fall),
    .ack_busy_o  (ack_busy)
  );

  hpd_tx_hold #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_i      (dsp_wr),
    .wdata_i   (dsp_wdata),
    .irq_en_i  (tx_irq_en),
    .move_i    (move),
    .empty_o   (tx_empty),
    .word_o    (hold_word),
    .irq_o     (tx_irq),
    .overrun_o (tx_overrun)
  );

  hpd_rx_unpack #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W),
    .LOW_ADDR  (LOW_ADDR),
    .MODE_W    (MODE_W)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .tx_empty_i  (tx_empty),
    .hold_word_i (hold_word),
    .mode_i      (width_mode),
    .ack_raw_i   (dma_ack),
    .ack_fall_i  (ack_fall),
    .ack_busy_i  (ack_busy),
    .move_o      (move),
    .req_o       (dma_req),
    .bus_data_o  (host_data),
    .bus_oe_o    (host_oe)
  );

  // R6
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    host_oe == dma_ack);
endmodule

// File: tb/tb_hpd_unpacker.sv
`timescale 1ns/1ps
module tb_hpd_unpacker;
  logic        clk;
  logic        rst_n;
  logic        dsp_wr;
  logic [23:0] dsp_wdata;
  logic        tx_irq_en;
  logic [1:0]  width_mode;
  logic        tx_empty, tx_irq, tx_overrun, dma_req;
  logic        dma_ack;
  logic [7:0]  host_data;
  logic        host_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  hpd_unpacker dut (
    .clk(clk), .rst_n(rst_n), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata),
    .tx_irq_en(tx_irq_en), .width_mode(width_mode), .tx_empty(tx_empty),
    .tx_irq(tx_irq), .tx_overrun(tx_overrun), .dma_req(dma_req),
    .dma_ack(dma_ack), .host_data(host_data), .host_oe(host_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic dsp_write(input logic [23:0] w);
    @(negedge clk);
    dsp_wr = 1'b1; dsp_wdata = w;
    @(negedge clk);
    dsp_wr = 1'b0;
  endtask

  // One byte handshake; checks request drop, bus value and re-request
  task automatic read_byte(input logic [7:0] exp_b, input logic more, input string rq);
    @(negedge clk);
    chk({rq, " req before ack"}, dma_req, 1);
    dma_ack = 1'b1;
    #0.5;
    chk("R6 oe high", host_oe, 1);
    chk({rq, " byte"}, host_data, exp_b);
    repeat (3) @(negedge clk);
    chk("R5 req dropped", dma_req, 0);
    dma_ack = 1'b0;
    #0.5;
    chk("R6 oe low", host_oe, 0);
    repeat (4) @(negedge clk);
    chk({rq, " req after ack"}, dma_req, more);
  endtask

  task automatic t_reset;
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 req", dma_req, 0);
    chk("R1 oe", host_oe, 0);
    chk("R1 overrun", tx_overrun, 0);
    chk("R1 irq", tx_irq, 0);
  endtask

  task automatic t_full_word_irq;
    tx_irq_en = 1'b1; width_mode = 2'd0;
    @(negedge clk);
    chk("R2 irq when empty", tx_irq, 1);
    dsp_write(24'hA1B2C3);
    chk("R2 empty cleared", tx_empty, 0);
    chk("R2 irq low", tx_irq, 0);
    @(negedge clk);
    chk("R3 empty again", tx_empty, 1);
    chk("R3 second irq", tx_irq, 1);
    chk("R5 req", dma_req, 1);
    read_byte(8'hA1, 1, "R4 high");
    read_byte(8'hB2, 1, "R7 mid");
    read_byte(8'hC3, 0, "R8 low");
    tx_irq_en = 1'b0;
    @(negedge clk);
    chk("R2 irq disabled", tx_irq, 0);
  endtask

  task automatic t_modes;
    width_mode = 2'd1;
    dsp_write(24'h123456);
    @(negedge clk);
    read_byte(8'h34, 1, "R4 mode1 mid");
    read_byte(8'h56, 0, "R4 mode1 low");
    width_mode = 2'd2;
    dsp_write(24'h789ABC);
    @(negedge clk);
    read_byte(8'hBC, 0, "R4 mode2 low");
    width_mode = 2'd3;
    dsp_write(24'hDEF012);
    @(negedge clk);
    read_byte(8'h12, 0, "R4 mode3 low");
  endtask

  task automatic t_pipeline;
    width_mode = 2'd0;
    dsp_write(24'h010203);
    @(negedge clk);
    dsp_write(24'h040506);
    chk("R10 second word held", tx_empty, 0);
    width_mode = 2'd1;
    read_byte(8'h01, 1, "R10 w1 high");
    read_byte(8'h02, 1, "R10 w1 mid");
    read_byte(8'h03, 1, "R8 w1 low then reload");
    chk("R8 holding freed", tx_empty, 1);
    read_byte(8'h05, 1, "R10 w2 mid");
    read_byte(8'h06, 0, "R10 w2 low");
  endtask

  task automatic t_overrun;
    width_mode = 2'd0;
    dsp_write(24'h111111);
    @(negedge clk);
    dsp_write(24'h222222);
    chk("R9 no overrun yet", tx_overrun, 0);
    dsp_write(24'h333333);
    chk("R9 overrun set", tx_overrun, 1);
    chk("R9 still full", tx_empty, 0);
    read_byte(8'h11, 1, "R9 w1 high");
    read_byte(8'h11, 1, "R9 w1 mid");
    read_byte(8'h11, 1, "R9 w1 low");
    read_byte(8'h22, 1, "R9 kept high");
    read_byte(8'h22, 1, "R9 kept mid");
    read_byte(8'h22, 0, "R9 kept low");
    chk("R9 overrun sticky", tx_overrun, 1);
  endtask

  initial begin
    dsp_wr = 0; dsp_wdata = '0; tx_irq_en = 0; width_mode = '0; dma_ack = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_word_irq();
    t_modes();
    t_pipeline();
    t_overrun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule